// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital timing controller that sits beside a 10-bit successive-approximation converter. Software raises a start request together with a 4-bit acquisition code and a 3-bit clock-select code. The block samples both codes at that moment. It then derives the per-bit conversion period (one TAD) either by dividing the system clock or from a slow external RC clock, which it synchronizes internally. It can keep the input sampling for a programmed number of TAD periods and then moves straight into the conversion phase, with no change visible in between.

The conversion is 12 TAD long. One setup period comes first. Ten decision periods follow, MSB first: in each one the block presents a trial code to the comparison DAC and keeps or drops the trial bit according to the comparator input. A final period writes the result register. Busy stays high from the accepted start until the end of the last period. At that point busy falls and a single-cycle done pulse is raised. Dropping the enable input abandons the work in progress at once.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, busy_o and done_o are low and result_o is zero.
- R2: A system-clock TAD lasts 2, 4, 8, 16, 32 or 64 clocks for clk_sel_i codes 000, 100, 001, 101, 010 and 110. With acquisition code 0, the time from busy rising to done is exactly 12 TAD.
- R3: clk_sel_i code 011 uses each rising edge of rc_clk_i as one TAD. Code 111 uses every fourth rising edge. One conversion therefore spans 12 or 48 rc_clk_i periods, within one period of synchronization slack.
- R4: With acq_code_i equal to 0000, conversion starts on the accepted start with no acquisition period.
- R5: A nonzero acq_code_i inserts an acquisition period before conversion. Codes 1 to 7 give 2, 4, 6, 8, 12, 16 and 20 TAD, and codes 8 to 15 give 20 TAD. Busy stays high and nothing else changes at the boundary between acquisition and conversion.
- R6: done_o is a one-cycle pulse raised on the same clock edge on which busy_o falls. busy_o never falls during a normal conversion before that edge.
- R7: The ten decisions run MSB first. trial_o equals the bits already kept OR'd with the bit under test, and a bit is kept when cmp_i is 1. result_o takes the final code only when done_o is raised and holds its value at all other times.
- R8: clk_sel_i and acq_code_i are sampled only when a start is accepted. Changing them while busy does not alter the timing of the run in progress.
- R9: Driving en_i low returns the block to idle on the next edge. It raises no done pulse and leaves result_o unchanged. A start is accepted only while en_i is high.
- R10: A start_i pulse that arrives while busy_o is high is ignored. The run in progress keeps its timing and gives exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Converter enable; low aborts and holds the block idle |
| start_i | input | 1 | Start request, sampled on every clock edge |
| acq_code_i | input | 4 | Acquisition length code |
| clk_sel_i | input | 3 | TAD source and divide select |
| rc_clk_i | input | 1 | Slow asynchronous RC clock |
| cmp_i | input | 1 | Comparator decision: 1 means the input is at or above trial_o |
| trial_o | output | 10 | Trial code driven to the comparison DAC |
| busy_o | output | 1 | High from an accepted start until completion or abort |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Last completed conversion result |

## Verification
The hardest case to reach from the ports is a code change or a repeated start landing on a run that is already under way. This matters most inside the silent acquisition window, where nothing on the ports shows which phase is active. The stimulus starts a run with a long acquisition code and a mid-range divider. It then rewrites both codes, and separately pulses start again, a fixed number of cycles later, while busy is still high. The scoreboard expects the latency that belongs to the originally sampled codes and exactly one result. Aborts are placed in the middle of a run, and the bench then confirms that no result item is produced and the previous result remains on result_o.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_SYS,
    SRC_RC,
    SRC_RC_DIV4
  } tad_src_e;

  // Non-monotonic select encoding: bit 2 doubles the divide, bits 1:0 pick the octave.
  function automatic logic [6:0] sys_divide(input logic [2:0] code);
    logic [6:0] div;
    case (code)
      3'b000:  div = 7'd2;
      3'b100:  div = 7'd4;
      3'b001:  div = 7'd8;
      3'b101:  div = 7'd16;
      3'b010:  div = 7'd32;
      3'b110:  div = 7'd64;
      default: div = 7'd2;
    endcase
    return div;
  endfunction

  function automatic tad_src_e tad_source(input logic [2:0] code);
    tad_src_e src;
    case (code)
      3'b011:  src = SRC_RC;
      3'b111:  src = SRC_RC_DIV4;
      default: src = SRC_SYS;
    endcase
    return src;
  endfunction

  // Acquisition length in TAD units; codes above 7 saturate.
  function automatic logic [4:0] acq_length(input logic [3:0] code);
    logic [4:0] len;
    case (code)
      4'd0:    len = 5'd0;
      4'd1:    len = 5'd2;
      4'd2:    len = 5'd4;
      4'd3:    len = 5'd6;
      4'd4:    len = 5'd8;
      4'd5:    len = 5'd12;
      4'd6:    len = 5'd16;
      default: len = 5'd20;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen
  import adc_seq_pkg::*;
#(
  parameter int DIV_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int RC_DIV      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  input  logic       rc_clk_i,
  output logic       tick_o
);

  localparam int RCW = (RC_DIV > 1) ? $clog2(RC_DIV) : 1;

  logic [SYNC_STAGES-1:0] rc_sync_q;
  logic                   rc_prev_q;
  logic                   rc_rise;
  logic [DIV_W-1:0]       div_cnt_q, div_cnt_d;
  logic [RCW-1:0]         rc_cnt_q, rc_cnt_d;
  logic [DIV_W-1:0]       div_last;
  tad_src_e               src;
  logic                   tick_sys, tick_rc;

  // Synchronizer chain for the asynchronous RC clock.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rc_sync_q[0] <= 1'b0;
          else        rc_sync_q[0] <= rc_clk_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rc_sync_q[s] <= 1'b0;
          else        rc_sync_q[s] <= rc_sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc_prev_q <= 1'b0;
    else        rc_prev_q <= rc_sync_q[SYNC_STAGES-1];
  end

  assign rc_rise  = rc_sync_q[SYNC_STAGES-1] & ~rc_prev_q;
  assign src      = tad_source(sel_i);
  assign div_last = DIV_W'(sys_divide(sel_i) - 7'd1);

  assign tick_sys = run_i && (src == SRC_SYS) && (div_cnt_q == div_last);
  assign tick_rc  = run_i && rc_rise &&
                    ((src == SRC_RC) ||
                     ((src == SRC_RC_DIV4) && (rc_cnt_q == RCW'(RC_DIV - 1))));
  assign tick_o   = tick_sys | tick_rc;

  always_comb begin
    div_cnt_d = div_cnt_q;
    rc_cnt_d  = rc_cnt_q;
    if (restart_i || !run_i) begin
      div_cnt_d = '0;
      rc_cnt_d  = '0;
    end else begin
      if (src == SRC_SYS) begin
        div_cnt_d = tick_sys ? '0 : div_cnt_q + 1'b1;
      end
      if (rc_rise) begin
        rc_cnt_d = (rc_cnt_q == RCW'(RC_DIV - 1)) ? '0 : rc_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      rc_cnt_q  <= '0;
    end else begin
      div_cnt_q <= div_cnt_d;
      rc_cnt_q  <= rc_cnt_d;
    end
  end

  // R2
  // tick_spacing_chk: every TAD source produces at least two clocks per period
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int STEPS  = 12,
  parameter int STEP_W = 4,
  parameter int ACQ_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [3:0]        acq_code_i,
  input  logic [2:0]        clk_sel_i,
  input  logic              tick_i,
  output logic [2:0]        sel_o,
  output logic              accept_o,
  output logic              conv_o,
  output logic [STEP_W-1:0] step_o,
  output logic              commit_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [ACQ_W-1:0]  acq_q, acq_d;
  logic [2:0]        sel_q, sel_d;
  logic              done_q, done_d;
  logic [ACQ_W-1:0]  acq_len;

  assign acq_len  = ACQ_W'(acq_length(acq_code_i));
  assign accept_o = (state_q == ST_IDLE) && en_i && start_i;
  assign commit_o = (state_q == ST_CONV) && en_i && tick_i &&
                    (step_q == STEP_W'(STEPS - 1));

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    acq_d   = acq_q;
    sel_d   = sel_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          sel_d   = clk_sel_i;
          acq_d   = acq_len;
          step_d  = '0;
          state_d = (acq_len == '0) ? ST_CONV : ST_ACQ;
        end
      end
      ST_ACQ: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else if (tick_i) begin
          if (acq_q == ACQ_W'(1)) begin
            acq_d   = '0;
            state_d = ST_CONV;
          end else begin
            acq_d = acq_q - 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else if (tick_i) begin
          if (commit_o) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      acq_q   <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      acq_q   <= acq_d;
      sel_q   <= sel_d;
      done_q  <= done_d;
    end
  end

  assign sel_o  = sel_q;
  assign conv_o = (state_q == ST_CONV);
  assign step_o = step_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R6
  // done_with_fall_chk: done coincides with the falling edge of busy
  done_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9
  // abort_idle_chk: a low enable leaves the block idle with no done pulse
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!busy_o && !done_o));

  // R8
  // code_hold_chk: the latched select does not move while a run is in progress
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(sel_q));

  // R10
  // restart_ignored_chk: start during conversion neither restarts nor jumps steps
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_o && en_i && start_i && !tick_i) |=> (conv_o && $stable(step_q)));

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_W  = 10,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              conv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              tick_i,
  input  logic              commit_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  trial_o,
  output logic [RES_W-1:0]  result_o
);

  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] bit_mask;

  // Step 1 tests the MSB and step RES_W tests the LSB; step 0 is setup.
  generate
    for (genvar g = 0; g < RES_W; g++) begin : g_mask
      assign bit_mask[g] = conv_i && (step_i == STEP_W'(RES_W - g));
    end
  endgenerate

  assign trial_o = sar_q | bit_mask;

  always_comb begin
    sar_d = sar_q;
    res_d = res_q;
    if (clear_i) begin
      sar_d = '0;
    end else if (tick_i && (bit_mask != '0) && cmp_i) begin
      sar_d = sar_q | bit_mask;
    end
    if (commit_i) begin
      res_d = sar_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      sar_q <= sar_d;
      res_q <= res_d;
    end
  end

  assign result_o = res_q;

  // R7
  // result_hold_chk: the result moves only on a commit
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(result_o));

  // R7
  // single_trial_bit_chk: at most one bit is under test at a time
  single_trial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial_o & ~sar_q));

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RC_DIV      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [3:0]       acq_code_i,
  input  logic [2:0]       clk_sel_i,
  input  logic             rc_clk_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  localparam int STEPS  = RES_W + 2;
  localparam int STEP_W = $clog2(STEPS);
  localparam int DIV_W  = 7;
  localparam int ACQ_W  = 5;

  logic              tick;
  logic              accept;
  logic              conv;
  logic              commit;
  logic [2:0]        sel_q;
  logic [STEP_W-1:0] step;

  adc_seq_fsm #(
    .STEPS (STEPS),
    .STEP_W(STEP_W),
    .ACQ_W (ACQ_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .start_i   (start_i),
    .acq_code_i(acq_code_i),
    .clk_sel_i (clk_sel_i),
    .tick_i    (tick),
    .sel_o     (sel_q),
    .accept_o  (accept),
    .conv_o    (conv),
    .step_o    (step),
    .commit_o  (commit),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  adc_tad_gen #(
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES),
    .RC_DIV     (RC_DIV)
  ) u_tad (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (busy_o),
    .restart_i(accept),
    .sel_i    (sel_q),
    .rc_clk_i (rc_clk_i),
    .tick_o   (tick)
  );

  adc_sar_reg #(
    .RES_W (RES_W),
    .STEP_W(STEP_W)
  ) u_sar (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .conv_i  (conv),
    .step_i  (step),
    .tick_i  (tick),
    .commit_i(commit),
    .cmp_i   (cmp_i),
    .trial_o (trial_o),
    .result_o(result_o)
  );

endmodule

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;

  localparam int RC_P = 10;

  typedef struct {
    logic [9:0] res;
    int         lo;
    int         hi;
    string      req;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       start = 1'b0;
  logic [3:0] acq = '0;
  logic [2:0] sel = '0;
  logic       rc_clk = 1'b0;
  logic       cmp;
  logic [9:0] vin = '0;
  logic [9:0] trial;
  logic       busy, done;
  logic [9:0] result;

  int        checks = 0;
  int        errors = 0;
  int        cyc = 0;
  int        busy_t = 0;
  logic      busy_prev = 1'b0;
  logic      abort_exp = 1'b0;
  exp_item_t sb_q[$];

  always #4 clk = ~clk;
  always #(RC_P * 4) rc_clk = ~rc_clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp = (vin >= trial);

  adc_conv_sequencer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .start_i   (start),
    .acq_code_i(acq),
    .clk_sel_i (sel),
    .rc_clk_i  (rc_clk),
    .cmp_i     (cmp),
    .trial_o   (trial),
    .busy_o    (busy),
    .done_o    (done),
    .result_o  (result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tad_of(input logic [2:0] s);
    case (s)
      3'b000: return 2;
      3'b100: return 4;
      3'b001: return 8;
      3'b101: return 16;
      3'b010: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int acq_tad(input logic [3:0] a);
    int t[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
    return (a > 7) ? 20 : t[a];
  endfunction

  // Monitor: pops expected items when results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_prev) busy_t = cyc;
      if (busy_prev && !busy && !done && !abort_exp) begin
        chk(1'b0, "R6 busy fell without done", 0, 1);
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9/R10 unexpected done", 1, 0);
        end else begin
          exp_item_t it;
          int lat;
          it  = sb_q.pop_front();
          lat = cyc - busy_t;
          chk(result == it.res, {it.req, " R7 result"}, int'(result), int'(it.res));
          chk(lat >= it.lo && lat <= it.hi, {it.req, " latency"}, lat, it.lo);
          chk(!busy, {it.req, " R6 busy low with done"}, int'(busy), 0);
        end
      end
      busy_prev = busy;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    wait_cycles(3);
  endtask

  // Driver: starts a run and pushes the expected item.
  task automatic run_conv(input logic [9:0] v, input logic [3:0] a, input logic [2:0] s,
                          input int lo, input int hi, input string req);
    exp_item_t it;
    vin = v;
    acq = a;
    sel = s;
    it.res = v;
    it.lo  = lo;
    it.hi  = hi;
    it.req = req;
    sb_q.push_back(it);
    pulse_start();
  endtask

  task automatic sys_conv(input logic [9:0] v, input logic [3:0] a, input logic [2:0] s,
                          input string req);
    int n;
    n = (acq_tad(a) + 12) * tad_of(s);
    run_conv(v, a, s, n, n, req);
    wait_idle();
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [9:0] saved;
    wait_cycles(3);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(result == '0, "R1 result", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cycles(2);
    en = 1'b1;
    wait_cycles(2);

    // R2 / R4: every system divide with no acquisition
    sys_conv(10'h2AA, 4'd0, 3'b000, "R2 R4 sel000");
    sys_conv(10'h155, 4'd0, 3'b100, "R2 sel100");
    sys_conv(10'h000, 4'd0, 3'b001, "R2 sel001");
    sys_conv(10'h3FF, 4'd0, 3'b101, "R2 sel101");
    sys_conv(10'h200, 4'd0, 3'b010, "R2 sel010");
    sys_conv(10'h001, 4'd0, 3'b110, "R2 sel110");

    // R3: RC clock, direct and divided by four
    run_conv(10'h1C7, 4'd0, 3'b011, 11 * RC_P, 12 * RC_P + 2, "R3 rc");
    wait_idle();
    run_conv(10'h238, 4'd0, 3'b111, 47 * RC_P, 48 * RC_P + 2, "R3 rc4");
    wait_idle();

    // R5: acquisition lookup including saturation
    for (int a = 1; a < 8; a++) begin
      sys_conv(10'(37 * a + 100), 4'(a), 3'b000, "R5 acq");
    end
    sys_conv(10'h0F0, 4'd9, 3'b000, "R5 acq sat9");
    sys_conv(10'h30F, 4'd15, 3'b100, "R5 acq sat15");

    // R8: codes changed mid-run must not matter
    run_conv(10'h2D2, 4'd2, 3'b001, 128, 128, "R8 code change");
    wait_cycles(20);
    sel = 3'b110;
    acq = 4'd7;
    wait_cycles(50);
    sel = 3'b000;
    acq = 4'd0;
    wait_idle();

    // R10: second start inside acquisition and inside conversion
    run_conv(10'h133, 4'd3, 3'b100, 72, 72, "R10 restart");
    wait_cycles(5);
    pulse_start();
    wait_cycles(40);
    pulse_start();
    wait_idle();
    chk(sb_q.size() == 0, "R10 one done", sb_q.size(), 0);

    // R9: abort during conversion and during acquisition
    saved = result;
    vin = 10'h0AB;
    acq = 4'd0;
    sel = 3'b001;
    abort_exp = 1'b1;
    pulse_start();
    wait_cycles(40);
    en = 1'b0;
    wait_cycles(2);
    chk(busy == 1'b0, "R9 abort busy", int'(busy), 0);
    chk(result == saved, "R9 result kept", int'(result), int'(saved));
    pulse_start();
    wait_cycles(2);
    chk(busy == 1'b0, "R9 start while disabled", int'(busy), 0);
    en = 1'b1;
    acq = 4'd4;
    sel = 3'b000;
    pulse_start();
    wait_cycles(6);
    en = 1'b0;
    wait_cycles(200);
    chk(result == saved, "R9 result kept acq", int'(result), int'(saved));
    abort_exp = 1'b0;
    en = 1'b1;
    wait_cycles(3);
    sys_conv(10'h321, 4'd1, 3'b101, "R9 after abort");

    wait_cycles(10);
    chk(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule